// File: doc/BRIEF.md
# Frame-Size Aware Transmit/Receive FIFO Pair

This block holds the two data queues of a serial master. The transmit queue fills from register writes and drains into the serial sequencer. The receive queue fills from the sequencer and drains through register reads. Each queue has storage for `CAP` words. The number of slots it actually uses is chosen at run time from two inputs: an extended-depth enable and the configured frame size.

Every flag compares the live occupancy against that current depth. The flags are empty, full and one-short-of-full, and they go straight to a status register. A frame that arrives at a full receive queue is thrown away. It raises a one-cycle overflow event for the raw interrupt logic and sets a sticky overflow status bit, which the next receive pop clears. Each queue also has a synchronous clear input.

Top module: `fifo_pair`

## Requirements
- R1: With `big_en`=1, the usable depth of each queue is CAP (32 by default) when `frame_size` is 0 to 8, CAP/2 when it is 9 to 16, and CAP/4 for any value of 17 or more.
- R2: With `big_en`=0, the usable depth is SMALL_DEPTH (4 by default), whatever `frame_size` is.
- R3: A transmit push made while the transmit occupancy is at or above the depth is discarded. The queue contents and the word order are left unchanged.
- R4: `*_full_nxt` is 1 when occupancy is at least depth−1, and it clears once occupancy falls below depth−1. `*_full` is 1 when occupancy is at least the depth.
- R5: A receive push made while the receive queue is full is dropped. In the next cycle `rx_ovf_evt` pulses high for exactly one cycle and `rx_ovf_sts` becomes 1.
- R6: A receive pop clears `rx_ovf_sts` and `rx_full`. `rx_empty` rises when the pop removes the last word.
- R7: Asserting `tx_clr` or `rx_clr` empties that queue at the next edge: empty becomes 1, and full and full-next become 0. `rx_clr` also clears `rx_ovf_sts`.
- R8: A pop from an empty queue leaves the pointers unchanged, and the read data of an empty queue is zero.
- R9: Each queue returns words in the order they were accepted. The head word is visible on the read data port before it is popped.
- R10: After reset both queues are empty, all full and full-next flags are 0, and both overflow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_en | input | 1 | Extended-depth enable |
| frame_size | input | FSW | Configured frame size in bits |
| tx_clr | input | 1 | Synchronous clear of the transmit queue |
| rx_clr | input | 1 | Synchronous clear of the receive queue |
| tx_push | input | 1 | Register-write push into the transmit queue |
| tx_wdata | input | DW | Transmit push data |
| tx_pop | input | 1 | Sequencer pop from the transmit queue |
| tx_rdata | output | DW | Transmit head word (zero when empty) |
| rx_push | input | 1 | Sequencer push into the receive queue |
| rx_wdata | input | DW | Receive push data |
| rx_pop | input | 1 | Register-read pop from the receive queue |
| rx_rdata | output | DW | Receive head word (zero when empty) |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit occupancy at depth |
| tx_full_nxt | output | 1 | Transmit occupancy at depth−1 or more |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive occupancy at depth |
| rx_full_nxt | output | 1 | Receive occupancy at depth−1 or more |
| rx_ovf_evt | output | 1 | One-cycle pulse for a dropped receive frame |
| rx_ovf_sts | output | 1 | Sticky overflow status, cleared by a receive pop |

## Verification
The bench builds the block with its default parameters: CAP=32, SMALL_DEPTH=4, a 6-bit frame size and 32-bit words. Because the frame-size field is 6 bits wide, the bench can reach sizes above 32 as well as every boundary of the depth table (8/9, 16/17, 32). It fills the transmit queue to each depth, pushes one word past it, and drains the queue to count the words that were accepted. The small depth of 4 makes receive overflow, the pop that clears it, and the empty-pop corner quick to reach.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
   // frame size limits for the three extended-depth bands
   localparam int unsigned BAND_FULL_MAX = 8;
   localparam int unsigned BAND_HALF_MAX = 16;

   function automatic int unsigned band_depth(input int unsigned fsize,
                                              input int unsigned cap);
      if (fsize <= BAND_FULL_MAX)      return cap;
      else if (fsize <= BAND_HALF_MAX) return cap / 2;
      else                             return cap / 4;
   endfunction
endpackage

// File: rtl/fp_depth_sel.sv
module fp_depth_sel
   import fifo_pair_pkg::*;
#(
   parameter int unsigned CAP         = 32,
   parameter int unsigned SMALL_DEPTH = 4,
   parameter int unsigned FSW         = 6,
   localparam int unsigned CW         = $clog2(CAP + 1)
) (
   input  logic           big_en,
   input  logic [FSW-1:0] frame_size,
   output logic [CW-1:0]  depth
);
   logic [CW-1:0] band;

   always_comb begin
      band = CW'(band_depth(int'(frame_size), CAP));
   end

   assign depth = big_en ? band : CW'(SMALL_DEPTH);
endmodule

// File: rtl/fp_lane.sv
module fp_lane #(
   parameter int unsigned DW         = 32,
   parameter int unsigned CAP        = 32,
   parameter bit          ZERO_EMPTY = 1'b1,
   localparam int unsigned AW        = $clog2(CAP),
   localparam int unsigned CW        = $clog2(CAP + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] depth,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full,
   output logic          full_nxt
);
   logic [DW-1:0] mem [CAP];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty    = (cnt == '0);
   assign full     = (cnt >= depth);
   assign full_nxt = (cnt >= (depth - CW'(1)));
   assign do_push  = push & ~full & ~clr;
   assign do_pop   = pop & ~empty & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   generate
      if (ZERO_EMPTY) begin : g_zero_head
         assign rdata = empty ? '0 : mem[rp];
      end else begin : g_raw_head
         assign rdata = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/fifo_pair.sv
module fifo_pair #(
   parameter int unsigned DW          = 32,
   parameter int unsigned CAP         = 32,
   parameter int unsigned SMALL_DEPTH = 4,
   parameter int unsigned FSW         = 6,
   localparam int unsigned CW         = $clog2(CAP + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           big_en,
   input  logic [FSW-1:0] frame_size,
   input  logic           tx_clr,
   input  logic           rx_clr,
   input  logic           tx_push,
   input  logic [DW-1:0]  tx_wdata,
   input  logic           tx_pop,
   output logic [DW-1:0]  tx_rdata,
   input  logic           rx_push,
   input  logic [DW-1:0]  rx_wdata,
   input  logic           rx_pop,
   output logic [DW-1:0]  rx_rdata,
   output logic           tx_empty,
   output logic           tx_full,
   output logic           tx_full_nxt,
   output logic           rx_empty,
   output logic           rx_full,
   output logic           rx_full_nxt,
   output logic           rx_ovf_evt,
   output logic           rx_ovf_sts
);
   generate
      if ((CAP & (CAP - 1)) != 0 || CAP < 16) begin : g_bad_cap
         $error("fifo_pair: CAP must be a power of two of at least 16");
      end
      if (SMALL_DEPTH < 2 || SMALL_DEPTH > CAP) begin : g_bad_small
         $error("fifo_pair: SMALL_DEPTH must lie in 2..CAP");
      end
   endgenerate

   logic [CW-1:0] depth;
   logic          rx_drop;

   fp_depth_sel #(.CAP(CAP), .SMALL_DEPTH(SMALL_DEPTH), .FSW(FSW)) u_depth (
      .big_en     (big_en),
      .frame_size (frame_size),
      .depth      (depth)
   );

   fp_lane #(.DW(DW), .CAP(CAP), .ZERO_EMPTY(1'b1)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tx_clr),
      .depth    (depth),
      .push     (tx_push),
      .wdata    (tx_wdata),
      .pop      (tx_pop),
      .rdata    (tx_rdata),
      .empty    (tx_empty),
      .full     (tx_full),
      .full_nxt (tx_full_nxt)
   );

   fp_lane #(.DW(DW), .CAP(CAP), .ZERO_EMPTY(1'b1)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rx_clr),
      .depth    (depth),
      .push     (rx_push),
      .wdata    (rx_wdata),
      .pop      (rx_pop),
      .rdata    (rx_rdata),
      .empty    (rx_empty),
      .full     (rx_full),
      .full_nxt (rx_full_nxt)
   );

   assign rx_drop = rx_push & rx_full & ~rx_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ovf_evt <= 1'b0;
         rx_ovf_sts <= 1'b0;
      end else begin
         rx_ovf_evt <= rx_drop;
         if (rx_clr)       rx_ovf_sts <= 1'b0;
         else if (rx_drop) rx_ovf_sts <= 1'b1;
         else if (rx_pop)  rx_ovf_sts <= 1'b0;
      end
   end
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
   parameter int unsigned DW          = 32,
   parameter int unsigned SMALL_DEPTH = 4,
   parameter int unsigned CW          = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          big_en,
   input logic [CW-1:0] depth,
   input logic          tx_clr,
   input logic          rx_clr,
   input logic          tx_push,
   input logic          tx_pop,
   input logic [DW-1:0] tx_rdata,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          tx_empty,
   input logic          tx_full,
   input logic          rx_empty,
   input logic          rx_full,
   input logic          rx_full_nxt,
   input logic          rx_ovf_evt,
   input logic          rx_ovf_sts
);
   AST_SMALL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n) !big_en |-> depth == CW'(SMALL_DEPTH)); // R2
   AST_TX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n) (tx_push && tx_full && !tx_pop && !tx_clr) |=> $stable(tx_rdata)); // R3
   AST_FULL_IMPLIES_NXT: assert property (@(posedge clk) disable iff (!rst_n) rx_full |-> rx_full_nxt); // R4
   AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rx_push && rx_full && !rx_clr) |=> (rx_ovf_evt && rx_ovf_sts)); // R5
   AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (rx_ovf_evt && !(rx_push && rx_full)) |=> !rx_ovf_evt); // R5
   AST_POP_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n) (rx_pop && !(rx_push && rx_full)) |=> !rx_ovf_sts); // R6
   AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) tx_clr |=> (tx_empty && !tx_full)); // R7
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) (rx_pop && rx_empty && !rx_push) |=> rx_empty); // R8
endmodule

bind fifo_pair fifo_pair_chk #(.DW(DW), .SMALL_DEPTH(SMALL_DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .big_en(big_en), .depth(depth),
   .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_push(tx_push), .tx_pop(tx_pop),
   .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_pop(rx_pop),
   .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
   .rx_full(rx_full), .rx_full_nxt(rx_full_nxt),
   .rx_ovf_evt(rx_ovf_evt), .rx_ovf_sts(rx_ovf_sts)
);

// File: tb/fifo_pair_tb.sv
`timescale 1ns/100ps
module fifo_pair_tb;
   localparam int DW = 32;
   localparam int FSW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic big_en = 1'b0;
   logic [FSW-1:0] frame_size = '0;
   logic tx_clr = 0, rx_clr = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
   logic [DW-1:0] tx_rdata, rx_rdata;
   logic tx_empty, tx_full, tx_full_nxt, rx_empty, rx_full, rx_full_nxt, rx_ovf_evt, rx_ovf_sts;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fifo_pair u_dut (
      .clk(clk), .rst_n(rst_n), .big_en(big_en), .frame_size(frame_size),
      .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_push(tx_push), .tx_wdata(tx_wdata),
      .tx_pop(tx_pop), .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_wdata(rx_wdata),
      .rx_pop(rx_pop), .rx_rdata(rx_rdata), .tx_empty(tx_empty), .tx_full(tx_full),
      .tx_full_nxt(tx_full_nxt), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_full_nxt(rx_full_nxt), .rx_ovf_evt(rx_ovf_evt), .rx_ovf_sts(rx_ovf_sts)
   );

   // {big_en, frame_size, expected depth}
   localparam int NV = 9;
   localparam logic [12:0] VEC [NV] = '{
      {1'b0, 6'd4,  6'd4},
      {1'b1, 6'd0,  6'd32},
      {1'b1, 6'd8,  6'd32},
      {1'b1, 6'd9,  6'd16},
      {1'b1, 6'd16, 6'd16},
      {1'b1, 6'd17, 6'd8},
      {1'b1, 6'd32, 6'd8},
      {1'b0, 6'd32, 6'd4},
      {1'b1, 6'd40, 6'd8}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_tx(input logic [DW-1:0] d);
      tx_push = 1; tx_wdata = d; tick(); tx_push = 0;
   endtask

   task automatic push_rx(input logic [DW-1:0] d);
      rx_push = 1; rx_wdata = d; tick(); rx_push = 0;
   endtask

   task automatic pop_rx();
      rx_pop = 1; tick(); rx_pop = 0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int got;
      logic [DW-1:0] last;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R10 reset state
      chk(tx_empty && rx_empty, "R10 empty", {tx_empty, rx_empty}, 3);
      chk(!tx_full && !tx_full_nxt && !rx_full && !rx_full_nxt, "R10 full flags",
          {tx_full, tx_full_nxt, rx_full, rx_full_nxt}, 0);
      chk(!rx_ovf_evt && !rx_ovf_sts, "R10 overflow", {rx_ovf_evt, rx_ovf_sts}, 0);

      // R1/R2/R3/R4/R9 depth table walk on the transmit queue
      for (int v = 0; v < NV; v++) begin
         int dep;
         big_en = VEC[v][12];
         frame_size = VEC[v][11:6];
         dep = int'(VEC[v][5:0]);
         tx_clr = 1; tick(); tx_clr = 0;
         for (int i = 0; i < dep - 1; i++) push_tx(DW'(v * 64 + i));
         chk(tx_full_nxt && !tx_full, "R4 depth-1", {tx_full_nxt, tx_full}, 2);
         push_tx(DW'(v * 64 + dep - 1));
         chk(tx_full && tx_full_nxt, "R4 depth", {tx_full, tx_full_nxt}, 3);
         push_tx(32'hDEAD_BEEF);
         got = 0;
         last = '0;
         while (!tx_empty && got < 40) begin
            if (got == 0) chk(tx_rdata == DW'(v * 64), "R9 head", tx_rdata, v * 64);
            last = tx_rdata;
            tx_pop = 1; tick(); tx_pop = 0;
            got++;
            if (got == 1) chk(!tx_full, "R4 full clears", tx_full, 0);
            if (got == 2) chk(!tx_full_nxt, "R4 full_nxt clears", tx_full_nxt, 0);
         end
         chk(got == dep, big_en ? "R1 depth" : "R2 depth", got, dep);
         chk(last == DW'(v * 64 + dep - 1), "R3 extra push discarded", last, v * 64 + dep - 1);
      end

      // R5/R6 receive overflow with depth 4
      big_en = 0; frame_size = 6'd8;
      for (int i = 0; i < 4; i++) push_rx(DW'(100 + i));
      chk(rx_full && !rx_ovf_sts, "R4 rx full", {rx_full, rx_ovf_sts}, 2);
      push_rx(32'd999);
      chk(rx_ovf_evt && rx_ovf_sts, "R5 overflow set", {rx_ovf_evt, rx_ovf_sts}, 3);
      tick();
      chk(!rx_ovf_evt && rx_ovf_sts, "R5 event one cycle", {rx_ovf_evt, rx_ovf_sts}, 1);
      chk(rx_rdata == 32'd100, "R9 rx head", rx_rdata, 100);
      pop_rx();
      chk(!rx_ovf_sts && !rx_full, "R6 pop clears", {rx_ovf_sts, rx_full}, 0);
      pop_rx(); pop_rx();
      chk(rx_rdata == 32'd103, "R5 dropped frame absent", rx_rdata, 103);
      pop_rx();
      chk(rx_empty, "R6 empty after last pop", rx_empty, 1);

      // R8 empty pop
      chk(rx_rdata == '0, "R8 empty data zero", rx_rdata, 0);
      pop_rx();
      chk(rx_empty && rx_rdata == '0, "R8 empty pop", rx_rdata, 0);
      push_rx(32'd55);
      chk(rx_rdata == 32'd55 && !rx_empty, "R8 pointers kept", rx_rdata, 55);

      // R7 clear
      push_rx(32'd56); push_rx(32'd57); push_rx(32'd58); push_rx(32'd59);
      chk(rx_ovf_sts, "R5 second overflow", rx_ovf_sts, 1);
      rx_clr = 1; tick(); rx_clr = 0;
      chk(rx_empty && !rx_full && !rx_full_nxt && !rx_ovf_sts, "R7 rx clear",
          {rx_empty, rx_full, rx_full_nxt, rx_ovf_sts}, 8);
      push_tx(32'd7); push_tx(32'd8);
      tx_clr = 1; tick(); tx_clr = 0;
      chk(tx_empty && tx_rdata == '0, "R7 tx clear", tx_rdata, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule